// File: doc/BRIEF.md
# Selectable Line Encoder/Decoder

This block is the bit-level line coding stage between packet framing and the modulator, with its receive-side counterpart placed after the demodulator's bit slicer. A four-bit mode register switches four transforms on or off, in any combination: scrambling with a self-synchronizing feedback shift register, differential (transition) coding, polarity inversion and Manchester coding. On transmit the block accepts one data bit per strobe and emits one line chip per cycle. That is one chip per bit, or two when Manchester coding is on. On receive it takes line chips that are already aligned to bit boundaries and undoes every enabled transform in reverse order.

Transmit applies the transforms in this order: scramble, differential, invert, Manchester. The scrambler uses the polynomial x^17 + x^12 + 1 and feeds its own output back into its register. Because of this the receive descrambler falls into step on its own after 17 correctly received bits, and no seed exchange is needed. Manchester chips that form an illegal pair are reported on an error output.

Top module: `line_codec`

## Requirements
- R1: After reset the mode register reads 4'b0010, so only differential coding is enabled. Both valid outputs are low. Mode bit 0 enables inversion, bit 1 differential coding, bit 2 scrambling and bit 3 Manchester coding.
- R2: A cycle with `cfgWe` high loads `cfgData` into the mode register, and `cfgMode` shows the new value on the next cycle.
- R3: With only inversion enabled, every transmitted chip is the complement of its data bit.
- R4: With only differential coding enabled, a data 1 toggles the line level and a data 0 keeps it. The level is 0 after reset.
- R5: With only Manchester enabled, a data 1 is sent as chip 1 followed by chip 0, and a data 0 as chip 0 followed by chip 1. The two chips appear in the two cycles after the strobe.
- R6: With only scrambling enabled, output chip n equals data bit n XOR chip n-17 XOR chip n-12. Chips before the first one after reset count as 0.
- R7: With Manchester enabled, the receive side outputs the first chip of each pair as the bit, before the remaining inverse steps. A pair of equal chips raises `rxErr` together with `rxBitValid`.
- R8: For each of the 16 mode values, a chip stream fed straight from the transmit side to the receive side gives back the original data with `rxErr` low.
- R9: The descrambler reproduces the data correctly from the 18th received bit onward, whatever its state was before.
- R10: A transmit strobe gives a valid chip one cycle later. A received chip (or the second chip of a Manchester pair) gives a valid bit one cycle later.
- R11: A mode write restarts receive Manchester pairing, so the next chip is treated as the first half of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Mode register write enable |
| cfgData | input | 4 | Mode value to load |
| cfgMode | output | 4 | Current mode register |
| txBitValid | input | 1 | Transmit data bit strobe |
| txBit | input | 1 | Transmit data bit |
| txChipValid | output | 1 | Line chip valid |
| txChip | output | 1 | Line chip |
| rxChipValid | input | 1 | Received chip strobe |
| rxChip | input | 1 | Received chip |
| rxBitValid | output | 1 | Decoded bit valid |
| rxBit | output | 1 | Decoded bit |
| rxErr | output | 1 | Illegal Manchester pair, valid with rxBitValid |

## Verification
The assertions assume three things about the inputs. While Manchester coding is on, no transmit strobe follows another strobe in the very next cycle. A mode write never falls in the same cycle as a strobe, nor while a chip pair is still in flight. Received Manchester chips arrive in aligned pairs. The bench meets all three: it spaces data strobes two cycles apart, and it waits for the pipeline to drain before writing the mode. Receive chips come either from the transmit side through a loopback mux or from tasks that drive whole pairs. The one deliberate exception is the half pair before a mode write in the pairing-restart test, and R11 exists to cover that case.

// File: rtl/line_codec_pkg.sv
package line_codec_pkg;

  localparam int MODE_W = 4;

  // Field order matches the mode register: bit 3 .. bit 0
  typedef struct packed {
    logic manch;
    logic scram;
    logic diff;
    logic inv;
  } lcMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic txLoad;     // new data bit accepted
    logic txSecond;   // emit second Manchester chip
    logic rxCapture;  // store first chip of a pair
    logic rxDecode;   // decode a complete symbol
  } lcStrobe_t;

endpackage

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import line_codec_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_MODE = 4'b0010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [MODE_W-1:0] cfgData,
  input  logic              txBitValid,
  input  logic              rxChipValid,
  output lcMode_t           mode,
  output lcStrobe_t         strb
);

  logic [MODE_W-1:0] modeReg;
  logic              txPend;
  logic              rxHalf;

  assign mode = lcMode_t'(modeReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= RESET_MODE;
    end else if (cfgWe) begin
      modeReg <= cfgData;
    end
  end

  // Second transmit chip pending
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPend <= 1'b0;
    end else if (cfgWe) begin
      txPend <= 1'b0;
    end else begin
      txPend <= txBitValid && mode.manch;
    end
  end

  // Receive pair phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHalf <= 1'b0;
    end else if (cfgWe) begin
      rxHalf <= 1'b0;
    end else if (rxChipValid && mode.manch) begin
      rxHalf <= !rxHalf;
    end
  end

  always_comb begin
    strb.txLoad    = txBitValid;
    strb.txSecond  = txPend;
    strb.rxCapture = rxChipValid && mode.manch && !rxHalf;
    strb.rxDecode  = rxChipValid && (!mode.manch || rxHalf);
  end

endmodule

// File: rtl/lc_tx_path.sv
module lc_tx_path
  import line_codec_pkg::*;
#(
  parameter int SCR_LEN = 17,
  parameter int SCR_TAP = 12
) (
  input  logic      clk,
  input  logic      rstN,
  input  lcMode_t   mode,
  input  lcStrobe_t strb,
  input  logic      txBit,
  output logic      txChipValid,
  output logic      txChip
);

  logic [SCR_LEN-1:0] scrReg;
  logic               lineLvl;
  logic               pendChip;
  logic               scrBit;
  logic               diffBit;
  logic               lineBit;

  always_comb begin
    scrBit  = mode.scram ? (txBit ^ scrReg[SCR_LEN-1] ^ scrReg[SCR_TAP-1]) : txBit;
    diffBit = mode.diff ? (lineLvl ^ scrBit) : scrBit;
    lineBit = diffBit ^ mode.inv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scrReg  <= '0;
      lineLvl <= 1'b0;
    end else if (strb.txLoad) begin
      if (mode.scram) scrReg <= {scrReg[SCR_LEN-2:0], scrBit};
      if (mode.diff)  lineLvl <= diffBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txChipValid <= 1'b0;
      txChip      <= 1'b0;
      pendChip    <= 1'b0;
    end else if (strb.txLoad) begin
      txChipValid <= 1'b1;
      txChip      <= lineBit;
      pendChip    <= !lineBit;
    end else if (strb.txSecond) begin
      txChipValid <= 1'b1;
      txChip      <= pendChip;
    end else begin
      txChipValid <= 1'b0;
    end
  end

endmodule

// File: rtl/lc_rx_path.sv
module lc_rx_path
  import line_codec_pkg::*;
#(
  parameter int SCR_LEN = 17,
  parameter int SCR_TAP = 12
) (
  input  logic      clk,
  input  logic      rstN,
  input  lcMode_t   mode,
  input  lcStrobe_t strb,
  input  logic      rxChip,
  output logic      rxBitValid,
  output logic      rxBit,
  output logic      rxErr
);

  logic [SCR_LEN-1:0] dscReg;
  logic               prevLvl;
  logic               firstChip;
  logic               symBit;
  logic               symErr;
  logic               lvlBit;
  logic               scrBit;
  logic               dataBit;

  always_comb begin
    symBit  = mode.manch ? firstChip : rxChip;
    symErr  = mode.manch && (firstChip == rxChip);
    lvlBit  = symBit ^ mode.inv;
    scrBit  = mode.diff ? (lvlBit ^ prevLvl) : lvlBit;
    dataBit = mode.scram ? (scrBit ^ dscReg[SCR_LEN-1] ^ dscReg[SCR_TAP-1]) : scrBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstChip <= 1'b0;
    end else if (strb.rxCapture) begin
      firstChip <= rxChip;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dscReg  <= '0;
      prevLvl <= 1'b0;
    end else if (strb.rxDecode) begin
      if (mode.scram) dscReg <= {dscReg[SCR_LEN-2:0], scrBit};
      if (mode.diff)  prevLvl <= lvlBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBitValid <= 1'b0;
      rxBit      <= 1'b0;
      rxErr      <= 1'b0;
    end else begin
      rxBitValid <= strb.rxDecode;
      if (strb.rxDecode) begin
        rxBit <= dataBit;
        rxErr <= symErr;
      end else begin
        rxErr <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/line_codec.sv
module line_codec
  import line_codec_pkg::*;
#(
  parameter int                SCR_LEN    = 17,
  parameter int                SCR_TAP    = 12,
  parameter logic [MODE_W-1:0] RESET_MODE = 4'b0010
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [3:0]  cfgData,
  output logic [3:0]  cfgMode,
  input  logic        txBitValid,
  input  logic        txBit,
  output logic        txChipValid,
  output logic        txChip,
  input  logic        rxChipValid,
  input  logic        rxChip,
  output logic        rxBitValid,
  output logic        rxBit,
  output logic        rxErr
);

  lcMode_t   mode;
  lcStrobe_t strb;

  assign cfgMode = mode;

  lc_ctrl #(.RESET_MODE(RESET_MODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .txBitValid(txBitValid), .rxChipValid(rxChipValid),
    .mode(mode), .strb(strb)
  );

  lc_tx_path #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_tx (
    .clk(clk), .rstN(rstN), .mode(mode), .strb(strb), .txBit(txBit),
    .txChipValid(txChipValid), .txChip(txChip)
  );

  lc_rx_path #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_rx (
    .clk(clk), .rstN(rstN), .mode(mode), .strb(strb), .rxChip(rxChip),
    .rxBitValid(rxBitValid), .rxBit(rxBit), .rxErr(rxErr)
  );

endmodule

// File: rtl/lc_checker.sv
module lc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic [3:0] cfgData,
  input logic [3:0] cfgMode,
  input logic       txBitValid,
  input logic       txChipValid,
  input logic       txChip,
  input logic       rxChipValid,
  input logic       rxBitValid,
  input logic       rxErr
);

  // R2: write lands next cycle
  a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> cfgMode == $past(cfgData));

  // R10: transmit latency
  a_r10_tx_latency: assert property (@(posedge clk) disable iff (!rstN)
    txBitValid |=> txChipValid);

  // R10: receive latency without Manchester
  a_r10_rx_latency: assert property (@(posedge clk) disable iff (!rstN)
    (rxChipValid && !cfgMode[3] && !cfgWe) |=> rxBitValid);

  // R5: Manchester emits two complementary chips
  a_r5_chip_pair: assert property (@(posedge clk) disable iff (!rstN)
    (txBitValid && cfgMode[3] && !cfgWe) |=> txChipValid ##1 (txChipValid && txChip != $past(txChip)));

  // R5: input rule, strobes spaced while Manchester is on
  a_r5_strobe_gap: assert property (@(posedge clk) disable iff (!rstN)
    (txBitValid && cfgMode[3]) |=> !txBitValid);

  // R7: error only reported with a decoded bit
  a_r7_err_with_bit: assert property (@(posedge clk) disable iff (!rstN)
    rxErr |-> rxBitValid);

endmodule

bind line_codec lc_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData), .cfgMode(cfgMode),
  .txBitValid(txBitValid), .txChipValid(txChipValid), .txChip(txChip),
  .rxChipValid(rxChipValid), .rxBitValid(rxBitValid), .rxErr(rxErr)
);

// File: tb/line_codec_bench.sv
`timescale 1ns/1ps
module line_codec_bench;

  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [3:0] cfgData = '0;
  logic [3:0] cfgMode;
  logic txBitValid = 1'b0, txBit = 1'b0;
  logic txChipValid, txChip;
  logic rxValidDrv = 1'b0, rxChipDrv = 1'b0;
  logic loopOn = 1'b0;
  logic rxChipValid, rxChip;
  logic rxBitValid, rxBit, rxErr;

  int vecCnt = 0;
  int failCnt = 0;

  logic txLog [0:1023];
  int   txCnt = 0;
  logic rxLog [0:1023];
  logic errLog [0:1023];
  int   rxCnt = 0;
  logic sent [0:127];

  always #HALF clk = ~clk;

  assign rxChipValid = loopOn ? txChipValid : rxValidDrv;
  assign rxChip      = loopOn ? txChip      : rxChipDrv;

  line_codec u_line_codec (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData), .cfgMode(cfgMode),
    .txBitValid(txBitValid), .txBit(txBit), .txChipValid(txChipValid), .txChip(txChip),
    .rxChipValid(rxChipValid), .rxChip(rxChip),
    .rxBitValid(rxBitValid), .rxBit(rxBit), .rxErr(rxErr)
  );

  always @(negedge clk) begin
    if (txChipValid) begin
      txLog[txCnt] = txChip;
      txCnt = txCnt + 1;
    end
    if (rxBitValid) begin
      rxLog[rxCnt]  = rxBit;
      errLog[rxCnt] = rxErr;
      rxCnt = rxCnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    loopOn = 1'b0; txBitValid = 0; rxValidDrv = 0; cfgWe = 0;
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeCfg(input logic [3:0] v);
    cfgWe = 1'b1; cfgData = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    txBitValid = 1'b1; txBit = b;
    @(negedge clk);
    txBitValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic driveChip(input logic c);
    rxValidDrv = 1'b1; rxChipDrv = c;
    @(negedge clk);
    rxValidDrv = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 reset mode", cfgMode, 4'b0010);
    chk("R1 tx valid idle", txChipValid, 0);
    chk("R1 rx valid idle", rxBitValid, 0);
  endtask

  task automatic t_cfg();
    doReset();
    writeCfg(4'b1101);
    chk("R2 mode load", cfgMode, 4'b1101);
    writeCfg(4'b0110);
    chk("R2 mode reload", cfgMode, 4'b0110);
  endtask

  task automatic t_invert();
    doReset();
    writeCfg(4'b0001);
    txBitValid = 1; txBit = 1;
    @(negedge clk);
    txBitValid = 0;
    chk("R10 tx valid after strobe", txChipValid, 1);
    chk("R3 invert of 1", txChip, 0);
    @(negedge clk);
    chk("R10 tx idle after chip", txChipValid, 0);
    txBitValid = 1; txBit = 0;
    @(negedge clk);
    txBitValid = 0;
    chk("R3 invert of 0", txChip, 1);
  endtask

  task automatic t_diff();
    logic pat [0:5];
    logic lvl;
    int start;
    pat = '{1, 1, 0, 1, 0, 0};
    doReset();
    start = txCnt;
    for (int i = 0; i < 6; i++) sendBit(pat[i]);
    lvl = 0;
    for (int i = 0; i < 6; i++) begin
      lvl = lvl ^ pat[i];
      chk("R4 differential level", txLog[start+i], lvl);
    end
  endtask

  task automatic t_manch();
    int start;
    doReset();
    writeCfg(4'b1000);
    start = txCnt;
    sendBit(1); sendBit(0);
    @(negedge clk);
    chk("R5 chip count", txCnt - start, 4);
    chk("R5 one first chip", txLog[start], 1);
    chk("R5 one second chip", txLog[start+1], 0);
    chk("R5 zero first chip", txLog[start+2], 0);
    chk("R5 zero second chip", txLog[start+3], 1);
  endtask

  task automatic t_scramble();
    logic hist [0:63];
    logic d, a, b;
    int start;
    doReset();
    writeCfg(4'b0100);
    start = txCnt;
    for (int i = 0; i < 40; i++) begin
      d = 1'($urandom);
      a = (i >= 17) ? hist[i-17] : 1'b0;
      b = (i >= 12) ? hist[i-12] : 1'b0;
      hist[i] = d ^ a ^ b;
      sendBit(d);
    end
    for (int i = 0; i < 40; i++) chk("R6 scrambled chip", txLog[start+i], hist[i]);
  endtask

  task automatic t_demanch();
    doReset();
    writeCfg(4'b1000);
    driveChip(1);
    chk("R10 no bit after half pair", rxBitValid, 0);
    driveChip(0);
    chk("R10 rx valid after pair", rxBitValid, 1);
    chk("R7 pair 10 bit", rxBit, 1);
    chk("R7 pair 10 no error", rxErr, 0);
    driveChip(0); driveChip(1);
    chk("R7 pair 01 bit", rxBit, 0);
    chk("R7 pair 01 no error", rxErr, 0);
    driveChip(1); driveChip(1);
    chk("R7 pair 11 error", rxErr, 1);
    driveChip(0); driveChip(0);
    chk("R7 pair 00 error", rxErr, 1);
    writeCfg(4'b0000);
    driveChip(1);
    chk("R10 rx valid plain", rxBitValid, 1);
    chk("R10 rx bit plain", rxBit, 1);
  endtask

  task automatic t_phase();
    doReset();
    writeCfg(4'b1000);
    driveChip(1);
    writeCfg(4'b1000);
    driveChip(0); driveChip(1);
    chk("R11 pairing restart valid", rxBitValid, 1);
    chk("R11 pairing restart bit", rxBit, 0);
    chk("R11 pairing restart error", rxErr, 0);
  endtask

  task automatic t_loop();
    int start;
    doReset();
    loopOn = 1'b1;
    for (int m = 0; m < 16; m++) begin
      writeCfg(4'(m));
      start = rxCnt;
      for (int i = 0; i < 24; i++) begin
        sent[i] = 1'($urandom);
        sendBit(sent[i]);
      end
      repeat (4) @(negedge clk);
      chk("R8 loopback count", rxCnt - start, 24);
      for (int i = 0; i < 24; i++) begin
        chk($sformatf("R8 loopback data mode %0d", m), rxLog[start+i], sent[i]);
        chk($sformatf("R8 loopback error mode %0d", m), errLog[start+i], 0);
      end
    end
    loopOn = 1'b0;
  endtask

  task automatic t_selfsync();
    int start;
    doReset();
    writeCfg(4'b0100);
    for (int i = 0; i < 30; i++) sendBit(1'($urandom));
    repeat (2) @(negedge clk);
    loopOn = 1'b1;
    start = rxCnt;
    for (int i = 0; i < 50; i++) begin
      sent[i] = 1'($urandom);
      sendBit(sent[i]);
    end
    repeat (3) @(negedge clk);
    for (int i = 17; i < 50; i++) chk("R9 descrambler in step", rxLog[start+i], sent[i]);
    loopOn = 1'b0;
  endtask

  initial begin
    #(HALF * 2 * 150000);
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    t_reset();
    t_cfg();
    t_invert();
    t_diff();
    t_manch();
    t_scramble();
    t_demanch();
    t_phase();
    t_loop();
    t_selfsync();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

endmodule